// File: doc/BRIEF.md
# Interrupt Request Latch with Masked Software Modify

This block holds one pending-request flag per peripheral channel and drives one interrupt line per channel toward an interrupt controller or an output pin multiplexer. A single-cycle pulse from a channel sets its flag. The flag stays set, and its interrupt line stays high, until software clears it.

Software reads and writes the flags through one 16-bit register. A write touches a flag only when the paired modify-enable bit in the same write word is 1. Software can therefore clear a serviced request without disturbing other pending ones. It can also set a flag to post a simulated request when testing a handler. The modify-enable bits are not stored, and a read returns them as zero.

Word layout: bits 3:0 carry the flag values, bits 7:4 carry the modify-enables (bit 4+i enables flag i), and bits 15:8 are reserved and must be written as zero.

Top module: `irq_post_latch`

## Requirements
- R1: In the first cycle after a synchronous active-high reset, all four flags are 0, `irq_out` is 4'b0000 and `rdata` is 16'h0000.
- R2: A 1 on `hw_set[i]` at a rising edge sets flag i. The flag stays 1 in later cycles until software clears it.
- R3: `irq_out[i]` equals flag i in every cycle. It goes low on the edge that clears the flag and stays low while the flag is 0.
- R4: A write (`sel`=1 and `wr_en`=1) that has `wdata[4+i]`=1 loads `wdata[i]` into flag i at that edge. A 1 sets the flag and raises `irq_out[i]` exactly as a hardware request does.
- R5: During a write, any flag whose modify-enable bit `wdata[4+i]` is 0 keeps its value.
- R6: When `sel` or `wr_en` is 0, no flag changes except through `hw_set`.
- R7: `rdata[3:0]` always equals the current flags, and `rdata[15:4]` is always zero, so the modify-enable positions read back as 0.
- R8: If `hw_set[i]` and a write that clears flag i arrive at the same edge, flag i ends up 1.
- R9: The values in `wdata[15:8]` have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register select for the write |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write word: values 3:0, modify-enables 7:4, reserved 15:8 |
| hw_set | input | 4 | Single-cycle set pulse for each channel |
| rdata | output | 16 | Combinational read of the flags, upper bits zero |
| irq_out | output | 4 | Interrupt request line for each channel |

## Verification
The bound checker verifies the following on every cycle:
- a hardware pulse always leaves its flag set on the next cycle;
- no flag falls unless a write selected it with its modify-enable bit;
- the read word mirrors the interrupt lines with the upper bits zero;
- the state is clean after reset.

The exact loaded value of each flag under every combination of start state, modify-enable pattern and write value can be shown only by the bench's sweeps. The same holds for three other behaviours:
- writes with no effect when `sel` or `wr_en` is low;
- the invariance to the reserved byte;
- set-over-clear precedence for every pairing of start state and pulse pattern.

// File: rtl/irq_post_latch_pkg.sv
package irq_post_latch_pkg;

    localparam int unsigned CH_COUNT  = 4;
    localparam int unsigned BUS_WIDTH = 16;

    // Software request decoded from one bus write
    typedef struct packed {
        logic [CH_COUNT-1:0] modify;
        logic [CH_COUNT-1:0] value;
    } sw_req_t;

    // Next value of one flag under set-over-write precedence
    function automatic logic flag_next(
        input logic cur,
        input logic hw,
        input logic mod,
        input logic val
    );
        logic r;
        if (hw)       r = 1'b1;
        else if (mod) r = val;
        else          r = cur;
        return r;
    endfunction

endpackage

// File: rtl/irl_write_decode.sv
module irl_write_decode
    import irq_post_latch_pkg::*;
#(
    parameter int unsigned NCH = CH_COUNT
) (
    input  logic             sel,
    input  logic             wr_en,
    input  logic [2*NCH-1:0] wfield,
    output sw_req_t          req
);
    localparam int unsigned MOD_LSB = NCH;

    logic hit;
    assign hit = sel & wr_en;

    always_comb begin
        req.value  = wfield[NCH-1:0];
        req.modify = hit ? wfield[MOD_LSB +: NCH] : '0;
    end
endmodule

// File: rtl/irl_flag_cell.sv
module irl_flag_cell
    import irq_post_latch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hw_pulse,
    input  logic sw_mod,
    input  logic sw_val,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= flag_next(flag, hw_pulse, sw_mod, sw_val);
    end
endmodule

// File: rtl/irl_read_port.sv
module irl_read_port #(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = 16
) (
    input  logic [NCH-1:0] flags,
    output logic [DW-1:0]  rword
);
    generate
        for (genvar b = 0; b < DW; b++) begin : g_rbit
            if (b < NCH) begin : g_live
                assign rword[b] = flags[b];
            end else begin : g_zero
                assign rword[b] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/irq_post_latch.sv
module irq_post_latch
    import irq_post_latch_pkg::*;
#(
    parameter int unsigned NCH = CH_COUNT,
    parameter int unsigned DW  = BUS_WIDTH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sel,
    input  logic           wr_en,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] hw_set,
    output logic [DW-1:0]  rdata,
    output logic [NCH-1:0] irq_out
);
    localparam int unsigned FIELD_W = 2 * NCH;

    sw_req_t        req;
    logic [NCH-1:0] flags;

    irl_write_decode #(.NCH(NCH)) u_dec (
        .sel    (sel),
        .wr_en  (wr_en),
        .wfield (wdata[FIELD_W-1:0]),
        .req    (req)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_cell
            irl_flag_cell u_cell (
                .clk      (clk),
                .rst      (rst),
                .hw_pulse (hw_set[i]),
                .sw_mod   (req.modify[i]),
                .sw_val   (req.value[i]),
                .flag     (flags[i])
            );
        end
    endgenerate

    assign irq_out = flags;

    irl_read_port #(.NCH(NCH), .DW(DW)) u_rd (
        .flags (flags),
        .rword (rdata)
    );
endmodule

// File: rtl/irq_post_latch_chk.sv
module irq_post_latch_chk #(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           sel,
    input logic           wr_en,
    input logic [DW-1:0]  wdata,
    input logic [NCH-1:0] hw_set,
    input logic [DW-1:0]  rdata,
    input logic [NCH-1:0] irq_out
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_out == '0 && rdata == '0));

    // R2
    hw_set_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((irq_out & $past(hw_set)) == $past(hw_set)));

    // R6
    idle_no_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !(sel && wr_en) |=> (($past(irq_out) & ~irq_out) == '0));

    // R5
    masked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && wr_en) |=>
            (($past(irq_out) & ~$past(wdata[2*NCH-1:NCH]) & ~irq_out) == '0));

    // R7
    read_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        rdata == {{(DW-NCH){1'b0}}, irq_out});
endmodule

bind irq_post_latch irq_post_latch_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .hw_set  (hw_set),
    .rdata   (rdata),
    .irq_out (irq_out)
);

// File: tb/test_irq_post_latch.sv
module test_irq_post_latch;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [3:0]  hw_set = '0;
    logic [15:0] rdata;
    logic [3:0]  irq_out;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_post_latch i_irq_post_latch (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en),
        .wdata(wdata), .hw_set(hw_set), .rdata(rdata), .irq_out(irq_out)
    );

    // Drive one cycle of inputs at the falling edge, then sample 1 time unit after the rising edge.
    task automatic cyc(input logic s, input logic w, input logic [15:0] d, input logic [3:0] h);
        @(negedge clk);
        sel = s; wr_en = w; wdata = d; hw_set = h;
        @(posedge clk);
        #1;
        sel = 1'b0; wr_en = 1'b0; wdata = '0; hw_set = '0;
    endtask

    task automatic chk(input string req, input logic [3:0] expv);
        checks++;
        if (irq_out !== expv || rdata !== {12'h000, expv}) begin
            failures++;
            $display("FAIL %s irq_out=%h rdata=%h expected irq_out=%h rdata=%h",
                     req, irq_out, rdata, expv, {12'h000, expv});
        end
    endtask

    task automatic load(input logic [3:0] s);
        cyc(1'b1, 1'b1, {8'h00, 4'hF, s}, 4'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 reset state", 4'h0);

        // R2 R3: pulses set flags, flags hold, lines follow
        cyc(1'b0, 1'b0, 16'h0, 4'b0101);
        chk("R2 pulse sets", 4'b0101);
        cyc(1'b0, 1'b0, 16'h0, 4'b0000);
        chk("R2 flag holds", 4'b0101);
        cyc(1'b1, 1'b1, 16'h0010, 4'b0000);
        chk("R3 line drops on clear", 4'b0100);

        // R4 R5 R9: full sweep of start state, modify-enables and values
        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 16; m++) begin
                for (int v = 0; v < 16; v++) begin
                    logic [3:0] e;
                    logic [7:0] junk;
                    load(s[3:0]);
                    junk = 8'(s * 16 + v) ^ 8'hA5;
                    cyc(1'b1, 1'b1, {junk, m[3:0], v[3:0]}, 4'h0);
                    e = (s[3:0] & ~m[3:0]) | (v[3:0] & m[3:0]);
                    chk("R4 R5 R9 masked write", e);
                end
            end
        end

        // R6: writes without both strobes are ignored
        for (int s = 0; s < 16; s++) begin
            load(s[3:0]);
            cyc(1'b0, 1'b1, {8'hFF, 4'hF, ~s[3:0]}, 4'h0);
            chk("R6 sel low ignored", s[3:0]);
            cyc(1'b1, 1'b0, {8'hFF, 4'hF, ~s[3:0]}, 4'h0);
            chk("R6 wr_en low ignored", s[3:0]);
        end

        // R8: set beats simultaneous clear, for every start state and pulse pattern
        for (int s = 0; s < 16; s++) begin
            for (int h = 0; h < 16; h++) begin
                load(s[3:0]);
                cyc(1'b1, 1'b1, 16'h00F0, h[3:0]);
                chk("R8 set wins over clear", h[3:0]);
            end
        end

        // R7: write enables never read back
        load(4'h0);
        cyc(1'b1, 1'b1, 16'hFFF0, 4'h0);
        chk("R7 enables read as zero", 4'h0);

        // R1: reset clears set flags
        load(4'hF);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 reset after activity", 4'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule